// File: doc/BRIEF.md
# Serial LED Shift-Out Controller

This block drives an external chain of serial-in parallel-out registers that holds a 17-bit LED pattern. It sends the pattern one bit at a time, most significant bit first, on a shift clock divided down from the core clock. A delay setting moves the rising edge of the shift clock later within each bit, which gives the external chip time after the data line settles. For chips with a separate output register, a one-cycle latch strobe follows the last bit. A second protocol setting, meant for plain shift chips, leaves the strobe out.

Software reaches the block through a small register port. In direct mode, a write of the data word starts a shift. In PWM mode, the pattern is taken from a 17-bit channel vector that comes from the waveform generators. Whenever that vector differs from the pattern last sent, a new shift starts. The pattern last sent is zero after reset, so a zero vector alone starts nothing. The busy flag sits in bit 31 of the data register, and any register write made while it is set is dropped.

Top module: `sled_ctrl`

## Requirements
- R1: After reset, every register reads zero, the busy flag is clear, and ser_data, ser_clk and ser_latch are low.
- R2: The data register (offset 0) reads the pattern last sent in bits 16:0 and the busy flag in bit 31, with zeros elsewhere. The divider (offset 1, bits 1:0), delay (offset 2, bits 7:0) and mode (offset 3: bit 1 PWM, bit 0 no-latch protocol) read back what was written.
- R3: In direct mode, a write to offset 0 while idle starts a shift of wdata[16:0], sent most significant bit first. Busy is set from the clock edge of the write until the shift, and the strobe if any, has finished. ser_data is low while idle.
- R4: Divider code c gives a bit period of 4<<c core cycles (/4, /8, /16 and /32).
- R5: Number the cycles of each bit period from 0 to N-1. Data is valid from cycle 0, and ser_clk is high for cycles d+1 up to d+N/2, where d is the effective delay.
- R6: A delay value above N/2-1 is used as N/2-1. The register still reads back the value written.
- R7: With mode bit 0 clear, ser_latch is high for exactly one cycle right after the last bit. With it set, no strobe is sent and busy clears right after the last bit.
- R8: Any register write made while busy is set has no effect.
- R9: In PWM mode, writes to offset 0 are ignored. While idle, a channel vector that differs from the pattern last sent starts a shift of that vector, including a change back to all zeros.
- R10: In PWM mode, when the pattern last sent is zero, a zero channel vector starts no shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| chan_vec | input | 17 | Channel outputs used as the pattern in PWM mode |
| ser_data | output | 1 | Serial data to the register chain |
| ser_clk | output | 1 | Divided shift clock |
| ser_latch | output | 1 | Output-register strobe after the last bit |

## Verification
A behavioural model of the serial pins is compared against the block on every cycle. The direct-mode patterns include alternating bits, single set bits at both ends and all zeros, so each one shows up a different mistake in bit order or in the bit count. The divider and delay pairs are chosen to cover the smallest period with no delay, the largest period with a mid-range delay, and a delay above the limit. These separate clock placement from saturation. The PWM sequence holds a zero vector, raises it, changes it during a shift and drops it back to zero, which shows that shifts follow changes in the vector and not its level.

// File: rtl/sled_pkg.sv
package sled_pkg;

    localparam int DIV_W = 2;
    localparam int DLY_W = 8;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_DLY  = 2'd2;
    localparam int BUSY_BIT = 31;
    localparam logic [ADDR_W-1:0] OFS_MODE = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2
    } sled_state_e;

    typedef struct packed {
        logic             pwm;
        logic             no_latch;
        logic [DIV_W-1:0] div;
        logic [DLY_W-1:0] dly;
    } sled_cfg_t;

    function automatic int div_cycles(input logic [DIV_W-1:0] code);
        return 4 << code;
    endfunction

    function automatic int eff_delay(input logic [DLY_W-1:0] dly,
                                     input logic [DIV_W-1:0] code);
        int lim;
        lim = div_cycles(code) / 2 - 1;
        return (int'(dly) > lim) ? lim : int'(dly);
    endfunction

endpackage

// File: rtl/sled_regs.sv
module sled_regs
    import sled_pkg::*;
#(
    parameter int NBITS = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output sled_cfg_t         cfg_q,
    output logic              start_dir,
    output logic [NBITS-1:0]  dir_pat
);

    logic wr_ok;

    assign wr_ok     = wr_en && !busy;
    assign start_dir = wr_ok && (addr == OFS_DATA) && !cfg_q.pwm;
    assign dir_pat   = wdata[NBITS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_ok) begin
            case (addr)
                OFS_DIV:  cfg_q.div <= wdata[DIV_W-1:0];
                OFS_DLY:  cfg_q.dly <= wdata[DLY_W-1:0];
                OFS_MODE: begin
                    cfg_q.pwm      <= wdata[1];
                    cfg_q.no_latch <= wdata[0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sled_timing.sv
module sled_timing
    import sled_pkg::*;
#(
    parameter int PH_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic [DLY_W-1:0] dly,
    output logic             bit_end,
    output logic             clk_hi
);

    logic [PH_W-1:0] phase;
    int ncyc;
    int dly_eff;
    int ph;

    always_comb begin
        ncyc    = div_cycles(div);
        dly_eff = eff_delay(dly, div);
        ph      = int'(phase);
        bit_end = run && (ph == ncyc - 1);
        clk_hi  = run && (ph > dly_eff) && (ph <= dly_eff + ncyc / 2);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || bit_end) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/sled_shifter.sv
module sled_shifter
    import sled_pkg::*;
#(
    parameter int NBITS = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_dir,
    input  logic [NBITS-1:0] dir_pat,
    input  logic             pwm,
    input  logic             no_latch,
    input  logic [NBITS-1:0] chan_vec,
    input  logic             bit_end,
    output logic             busy,
    output logic             running,
    output logic             ser_data,
    output logic             ser_latch,
    output logic [NBITS-1:0] last_pat
);

    localparam int CNT_W = $clog2(NBITS + 1);

    sled_state_e      state;
    logic [NBITS-1:0] shreg;
    logic [CNT_W-1:0] bitcnt;
    logic             start_pwm;
    logic             start;
    logic [NBITS-1:0] new_pat;

    assign busy      = (state != ST_IDLE);
    assign running   = (state == ST_SHIFT);
    assign start_pwm = pwm && (chan_vec != last_pat);
    assign start     = !busy && (start_dir || start_pwm);
    assign new_pat   = pwm ? chan_vec : dir_pat;
    assign ser_data  = running && shreg[NBITS-1];
    assign ser_latch = (state == ST_LATCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            last_pat <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_SHIFT;
                        shreg    <= new_pat;
                        last_pat <= new_pat;
                        bitcnt   <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (bit_end) begin
                        shreg <= {shreg[NBITS-2:0], 1'b0};
                        if (bitcnt == CNT_W'(NBITS - 1)) begin
                            bitcnt <= '0;
                            state  <= no_latch ? ST_IDLE : ST_LATCH;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sled_ctrl.sv
module sled_ctrl
    import sled_pkg::*;
#(
    parameter int NBITS = 17,
    parameter int PH_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NBITS-1:0]  chan_vec,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_latch
);

    localparam int PAD_W = BUSY_BIT - NBITS;

    sled_cfg_t        cfg_q;
    logic             busy;
    logic             running;
    logic             start_dir;
    logic [NBITS-1:0] dir_pat;
    logic [NBITS-1:0] last_pat;
    logic             bit_end;

    sled_regs #(.NBITS(NBITS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .busy      (busy),
        .cfg_q     (cfg_q),
        .start_dir (start_dir),
        .dir_pat   (dir_pat)
    );

    sled_timing #(.PH_W(PH_W)) u_timing (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .div     (cfg_q.div),
        .dly     (cfg_q.dly),
        .bit_end (bit_end),
        .clk_hi  (ser_clk)
    );

    sled_shifter #(.NBITS(NBITS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start_dir (start_dir),
        .dir_pat   (dir_pat),
        .pwm       (cfg_q.pwm),
        .no_latch  (cfg_q.no_latch),
        .chan_vec  (chan_vec),
        .bit_end   (bit_end),
        .busy      (busy),
        .running   (running),
        .ser_data  (ser_data),
        .ser_latch (ser_latch),
        .last_pat  (last_pat)
    );

    always_comb begin
        case (addr)
            OFS_DATA: rdata = {busy, {PAD_W{1'b0}}, last_pat};
            OFS_DIV:  rdata = DATA_W'(cfg_q.div);
            OFS_DLY:  rdata = DATA_W'(cfg_q.dly);
            default:  rdata = DATA_W'({cfg_q.pwm, cfg_q.no_latch});
        endcase
    end

endmodule

// File: rtl/sled_chk.sv
module sled_chk
    import sled_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             ser_clk,
    input logic             ser_data,
    input logic             ser_latch,
    input logic             wr_en,
    input logic [DIV_W-1:0] div_q,
    input logic [1:0]       mode_q
);

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_data && !ser_clk && !ser_latch));

    p_clk_in_shift_r5: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> (busy && !ser_latch));

    p_latch_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        ser_latch |=> !ser_latch);

    p_latch_ends_r7: assert property (@(posedge clk) disable iff (rst)
        ser_latch |=> !busy);

    p_div_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> $stable(div_q));

    p_mode_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> $stable(mode_q));

endmodule

bind sled_ctrl sled_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_latch (ser_latch),
    .wr_en     (wr_en),
    .div_q     (cfg_q.div),
    .mode_q    ({cfg_q.pwm, cfg_q.no_latch})
);

// File: tb/sled_ctrl_tb.sv
module sled_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [16:0] chan_vec = '0;
    logic        ser_data, ser_clk, ser_latch;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sled_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .chan_vec(chan_vec), .ser_data(ser_data),
        .ser_clk(ser_clk), .ser_latch(ser_latch)
    );

    // reference model state
    int          m_st = 0;   // 0 idle, 1 shifting, 2 strobe
    int          m_ph = 0;
    int          m_bit = 0;
    logic [16:0] m_pat = '0;
    logic [16:0] m_last = '0;
    logic [1:0]  m_div = '0;
    int          m_dly = 0;
    logic        m_nolat = 0;
    logic        m_pwm = 0;

    always @(posedge clk) begin
        int n;
        bit go;
        logic [16:0] spat;
        if (rst) begin
            m_st = 0; m_ph = 0; m_bit = 0; m_pat = '0; m_last = '0;
            m_div = '0; m_dly = 0; m_nolat = 0; m_pwm = 0;
        end else begin
            n = 4 << m_div;
            go = 0;
            spat = '0;
            if (m_st == 0) begin
                if (m_pwm && chan_vec != m_last) begin
                    go = 1; spat = chan_vec;
                end else if (wr_en && addr == 2'd0 && !m_pwm) begin
                    go = 1; spat = wdata[16:0];
                end
                if (wr_en) begin
                    case (addr)
                        2'd1: m_div = wdata[1:0];
                        2'd2: m_dly = int'(wdata[7:0]);
                        2'd3: begin m_pwm = wdata[1]; m_nolat = wdata[0]; end
                        default: ;
                    endcase
                end
            end
            if (m_st == 1) begin
                if (m_ph == n - 1) begin
                    m_ph = 0;
                    if (m_bit == 16) begin
                        m_bit = 0;
                        m_st = m_nolat ? 0 : 2;
                    end else m_bit++;
                end else m_ph++;
            end else if (m_st == 2) begin
                m_st = 0;
            end else if (go) begin
                m_st = 1; m_ph = 0; m_bit = 0; m_pat = spat; m_last = spat;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison of the pins and the busy flag
    always @(negedge clk) begin
        int n, d;
        logic e_clk, e_dat, e_lat;
        #1;
        if (!rst && !done) begin
            n = 4 << m_div;
            d = (m_dly > n / 2 - 1) ? n / 2 - 1 : m_dly;
            e_clk = (m_st == 1) && (m_ph >= d + 1) && (m_ph < d + 1 + n / 2);
            e_dat = (m_st == 1) && m_pat[16 - m_bit];
            e_lat = (m_st == 2);
            check("R5 ser_clk", 32'(ser_clk), 32'(e_clk));
            check("R3 ser_data", 32'(ser_data), 32'(e_dat));
            check("R7 ser_latch", 32'(ser_latch), 32'(e_lat));
            if (addr == 2'd0) check("R3 busy", 32'(rdata[31]), 32'(m_st != 0));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #2;
        check(req, rdata, exp);
        @(negedge clk);
        addr = 2'd0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while (m_st != 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        rd(2'd0, 32'h0, "R1 data");
        rd(2'd1, 32'h0, "R1 div");
        rd(2'd2, 32'h0, "R1 dly");
        rd(2'd3, 32'h0, "R1 mode");
        check("R1 pins", {29'b0, ser_data, ser_clk, ser_latch}, 32'h0);

        // R3 R4 R5: direct shift at /4 with zero delay
        wr(2'd0, 32'h0001_A5C3);
        repeat (5) @(negedge clk);
        rd(2'd0, 32'h8001_A5C3, "R2 busy during shift");
        // R8: writes while busy are dropped
        wr(2'd0, 32'h0000_0FFF);
        wr(2'd1, 32'h3);
        wr(2'd3, 32'h3);
        wait_idle();
        rd(2'd0, 32'h0001_A5C3, "R8 data kept");
        rd(2'd1, 32'h0, "R8 div kept");
        rd(2'd3, 32'h0, "R8 mode kept");

        // R4 R5: /32 with delay 5
        wr(2'd1, 32'h3);
        wr(2'd2, 32'h5);
        rd(2'd1, 32'h3, "R2 div readback");
        wr(2'd0, 32'hFFFF_0001);
        wait_idle();
        rd(2'd0, 32'h0001_0001, "R2 data bits only");

        // R6: delay above limit at /8
        wr(2'd1, 32'h1);
        wr(2'd2, 32'd20);
        rd(2'd2, 32'd20, "R6 raw readback");
        wr(2'd0, 32'h0001_0000);
        wait_idle();

        // R7: no-strobe protocol at /16
        wr(2'd1, 32'h2);
        wr(2'd2, 32'h2);
        wr(2'd3, 32'h1);
        wr(2'd0, 32'h0000_AAAA);
        wait_idle();
        rd(2'd0, 32'h0000_AAAA, "R7 no strobe data");
        wr(2'd3, 32'h0);
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h0);
        wait_idle();
        rd(2'd0, 32'h0, "R3 zeros sent");

        // R10: PWM mode with zero vector starts nothing
        wr(2'd3, 32'h2);
        repeat (20) @(negedge clk);
        rd(2'd0, 32'h0, "R10 zero vector idle");
        // R9: vector change starts a shift
        chan_vec = 17'h00005;
        repeat (10) @(negedge clk);
        rd(2'd0, 32'h8000_0005, "R9 shift of vector");
        chan_vec = 17'h1F000;
        wait_idle();
        wait_idle();
        rd(2'd0, 32'h0001_F000, "R9 follow-up shift");
        wr(2'd0, 32'h0000_0777);
        repeat (3) @(negedge clk);
        rd(2'd0, 32'h0001_F000, "R9 data write ignored");
        chan_vec = 17'h0;
        wait_idle();
        wait_idle();
        rd(2'd0, 32'h0, "R9 back to zeros");
        wr(2'd3, 32'h0);
        rd(2'd3, 32'h0, "R2 mode readback");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule